// File: doc/BRIEF.md
# Interleaved Scanline Attribute Interpolator

This block produces one shaded attribute (a colour channel or a depth value) per pixel for one of four slices in a rasterizer that deals scanlines out round-robin: a slice draws only the lines whose low Y bits equal its own index. For each triangle the block gets a start value F, its slope along the left edge, its slope across a line, and the low bits of the first line. It then walks F down the edge until it sits on the first line this slice owns. From then on, each edge step covers four lines.

Each span request carries a pixel count and a sub-pixel offset. The offset is the 4-bit distance, in sixteenths of a pixel, between the true left edge and the first whole pixel. The block scales the across-line slope by this offset with a serial shift-and-add multiplier and adds the result to a copy of the edge value. It then hands out one value per pixel on a valid/ready stream, adding the across-line slope each time. After the last pixel it moves the edge value on to the slice's next line.

Top module: `scan_attr_interp`

## Requirements
- R1: After reset, span_rdy and pix_valid stay 0 until a load, and span_go has no effect while the block has not been loaded.
- R2: A load captures F, the edge slope and the across slope. span_rdy rises exactly n+1 cycles after the load edge, where n = (slice_id − ld_line_lo) mod 4.
- R3: The edge value used by the first span is F + n × edge slope, with n as in R2.
- R4: The first pixel of a span equals edge value + floor(xerr × across slope / 16), where xerr is span_xerr read as an unsigned count of sixteenths.
- R5: For a span with span_len > 0 accepted while span_rdy is 1, pix_valid is first 1 exactly four cycles after the accepting edge.
- R6: Each later pixel equals the previous one plus the across slope. A span gives exactly span_len pixels, and pix_last is 1 only on the final one.
- R7: While pix_valid is 1 and pix_ready is 0, pix_data and pix_last hold their values.
- R8: After the final pixel is taken, span_rdy is 1 in the next cycle and the edge value has grown by four times the edge slope.
- R9: A span with span_len = 0 gives no pixels, keeps span_rdy at 1 and still advances the edge value by four times the edge slope.
- R10: ld_valid wins over everything else in the same cycle. It drops any span in progress and any span_go, clears pix_valid and span_rdy in the next cycle, and restarts the pre-step.
- R11: All values are 32-bit two's complement in 17.15 fixed point (sign, 16 integer bits, 15 fraction bits). Sums wrap modulo 2^32.

Top module ports (the top module is `scan_attr_interp`):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_id | input | 2 | Index of the scanline slice this instance serves |
| ld_valid | input | 1 | Load a new triangle's parameters |
| ld_line_lo | input | 2 | Low bits of the triangle's first scanline |
| ld_f | input | 32 | Start value on the left edge |
| ld_dedge | input | 32 | Change of the value per scanline along the left edge |
| ld_dx | input | 32 | Change of the value per pixel along a line |
| span_go | input | 1 | Start a span; taken when span_rdy is 1 |
| span_xerr | input | 4 | Sub-pixel offset of the first pixel, in sixteenths |
| span_len | input | 12 | Number of pixels in the span |
| span_rdy | output | 1 | Waiting for a span request |
| pix_valid | output | 1 | pix_data holds a pixel value |
| pix_ready | input | 1 | Consumer takes the pixel |
| pix_data | output | 32 | Interpolated value for the current pixel |
| pix_last | output | 1 | Current pixel is the final one of the span |

## Verification
Two things can land on the same clock edge: a new load, and a span action (a span request, or the handshake of a pixel). The bench provokes this by raising ld_valid while a span_go is also asserted, and again while pixels are still flowing mid-span. It judges the result by three things: pix_valid falls at once, the pre-step latency follows the new parameters, and the next span's first pixel is computed from the new load. Nothing from the interrupted span carries over.

// File: rtl/sai_pkg.sv
package sai_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_WAIT = 3'd2,
    ST_MUL  = 3'd3,
    ST_RUN  = 3'd4
  } sai_state_e;

  // Per-cycle strobes from the sequencer to the datapath
  typedef struct packed {
    logic ld;
    logic pre_step;
    logic scale;
    logic mul_start;
    logic work_load;
    logic pix_step;
    logic edge_adv;
  } sai_ctl_t;

endpackage

// File: rtl/sai_ctrl.sv
module sai_ctrl
  import sai_pkg::*;
#(
  parameter int SW = 2,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] slice_id,
  input  logic          ld_valid,
  input  logic [SW-1:0] ld_line_lo,
  input  logic          span_go,
  input  logic [LW-1:0] span_len,
  input  logic          pix_ready,
  input  logic          mul_done,
  output sai_ctl_t      ctl,
  output logic          span_rdy,
  output logic          pix_valid,
  output logic          pix_last
);

  sai_state_e    st_q, st_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] rem_q, rem_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    rem_d = rem_q;
    ctl   = '0;
    if (ld_valid) begin
      ctl.ld = 1'b1;
      st_d   = ST_PRE;
      cnt_d  = slice_id - ld_line_lo;
    end else begin
      unique case (st_q)
        ST_PRE: begin
          if (cnt_q != '0) begin
            ctl.pre_step = 1'b1;
            cnt_d        = cnt_q - SW'(1);
          end else begin
            ctl.scale = 1'b1;
            st_d      = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (span_go) begin
            if (span_len == '0) begin
              ctl.edge_adv = 1'b1;
            end else begin
              ctl.mul_start = 1'b1;
              rem_d         = span_len;
              st_d          = ST_MUL;
            end
          end
        end
        ST_MUL: begin
          if (mul_done) begin
            ctl.work_load = 1'b1;
            st_d          = ST_RUN;
          end
        end
        ST_RUN: begin
          if (pix_ready) begin
            if (rem_q == LW'(1)) begin
              ctl.edge_adv = 1'b1;
              st_d         = ST_WAIT;
            end else begin
              ctl.pix_step = 1'b1;
              rem_d        = rem_q - LW'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
    end
  end

  assign span_rdy  = (st_q == ST_WAIT);
  assign pix_valid = (st_q == ST_RUN);
  assign pix_last  = pix_valid && (rem_q == LW'(1));

endmodule

// File: rtl/sai_shift_mul.sv
module sai_shift_mul #(
  parameter int DW = 32,
  parameter int XB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [XB-1:0] xerr,
  input  logic [DW-1:0] mcand,
  output logic          done,
  output logic [DW-1:0] corr
);

  localparam int PW = DW + XB;
  localparam int CW = (XB > 1) ? $clog2(XB) : 1;

  logic                 busy_q, busy_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [XB-1:0]        xsh_q, xsh_d;
  logic signed [PW-1:0] msh_q, msh_d;
  logic signed [PW-1:0] prod_q, prod_d;
  logic signed [PW-1:0] addend, prod_sum;

  assign addend   = xsh_q[0] ? msh_q : '0;
  assign prod_sum = prod_q + addend;
  assign done     = busy_q && (cnt_q == CW'(XB - 1));
  // product already carries XB fraction bits of the offset: drop them
  assign corr     = prod_sum[PW-1:XB];

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    xsh_d  = xsh_q;
    msh_d  = msh_q;
    prod_d = prod_q;
    if (clr) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      xsh_d  = xerr;
      msh_d  = {{XB{mcand[DW-1]}}, mcand};
      prod_d = '0;
    end else if (busy_q) begin
      prod_d = prod_sum;
      msh_d  = msh_q <<< 1;
      xsh_d  = xsh_q >> 1;
      cnt_d  = cnt_q + CW'(1);
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      xsh_q  <= '0;
      msh_q  <= '0;
      prod_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      xsh_q  <= xsh_d;
      msh_q  <= msh_d;
      prod_q <= prod_d;
    end
  end

endmodule

// File: rtl/sai_datapath.sv
module sai_datapath
  import sai_pkg::*;
#(
  parameter int DW = 32,
  parameter int SH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sai_ctl_t      ctl,
  input  logic [DW-1:0] ld_f,
  input  logic [DW-1:0] ld_dedge,
  input  logic [DW-1:0] ld_dx,
  input  logic [DW-1:0] corr,
  output logic [DW-1:0] dx,
  output logic [DW-1:0] work
);

  logic [DW-1:0] f_q, f_d;
  logic [DW-1:0] de_q, de_d;
  logic [DW-1:0] dx_q, dx_d;
  logic [DW-1:0] wk_q, wk_d;

  always_comb begin
    f_d  = f_q;
    de_d = de_q;
    dx_d = dx_q;
    wk_d = wk_q;
    if (ctl.ld) begin
      f_d  = ld_f;
      de_d = ld_dedge;
      dx_d = ld_dx;
    end else begin
      if (ctl.pre_step || ctl.edge_adv) f_d = f_q + de_q;
      if (ctl.scale)     de_d = de_q << SH;
      if (ctl.work_load) wk_d = f_q + corr;
      if (ctl.pix_step)  wk_d = wk_q + dx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q  <= '0;
      de_q <= '0;
      dx_q <= '0;
      wk_q <= '0;
    end else begin
      f_q  <= f_d;
      de_q <= de_d;
      dx_q <= dx_d;
      wk_q <= wk_d;
    end
  end

  assign dx   = dx_q;
  assign work = wk_q;

endmodule

// File: rtl/scan_attr_interp.sv
module scan_attr_interp
  import sai_pkg::*;
#(
  parameter int DW    = 32,
  parameter int XB    = 4,
  parameter int LW    = 12,
  parameter int LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(LANES)-1:0]   slice_id,
  input  logic                       ld_valid,
  input  logic [$clog2(LANES)-1:0]   ld_line_lo,
  input  logic [DW-1:0]              ld_f,
  input  logic [DW-1:0]              ld_dedge,
  input  logic [DW-1:0]              ld_dx,
  input  logic                       span_go,
  input  logic [XB-1:0]              span_xerr,
  input  logic [LW-1:0]              span_len,
  output logic                       span_rdy,
  output logic                       pix_valid,
  input  logic                       pix_ready,
  output logic [DW-1:0]              pix_data,
  output logic                       pix_last
);

  localparam int SW = $clog2(LANES);

  sai_ctl_t      ctl;
  logic          mul_done;
  logic [DW-1:0] corr;
  logic [DW-1:0] dx;

  sai_ctrl #(.SW(SW), .LW(LW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .slice_id   (slice_id),
    .ld_valid   (ld_valid),
    .ld_line_lo (ld_line_lo),
    .span_go    (span_go),
    .span_len   (span_len),
    .pix_ready  (pix_ready),
    .mul_done   (mul_done),
    .ctl        (ctl),
    .span_rdy   (span_rdy),
    .pix_valid  (pix_valid),
    .pix_last   (pix_last)
  );

  sai_shift_mul #(.DW(DW), .XB(XB)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.ld),
    .start (ctl.mul_start),
    .xerr  (span_xerr),
    .mcand (dx),
    .done  (mul_done),
    .corr  (corr)
  );

  sai_datapath #(.DW(DW), .SH(SW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .ld_f     (ld_f),
    .ld_dedge (ld_dedge),
    .ld_dx    (ld_dx),
    .corr     (corr),
    .dx       (dx),
    .work     (pix_data)
  );

endmodule

// File: rtl/sai_chk.sv
module sai_chk #(
  parameter int DW = 32,
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic          span_go,
  input logic [LW-1:0] span_len,
  input logic          span_rdy,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic [DW-1:0] pix_data,
  input logic          pix_last
);

  // R7
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready && !ld_valid) |=> (pix_valid && $stable(pix_data) && $stable(pix_last)));

  // R10
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (!pix_valid && !span_rdy));

  // R5
  span_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (span_rdy && span_go && !ld_valid && span_len != '0) |=> (!pix_valid && !span_rdy));

  // R8
  last_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && pix_last && !ld_valid) |=> (span_rdy && !pix_valid));

  // R9
  empty_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (span_rdy && span_go && span_len == '0 && !ld_valid) |=> (span_rdy && !pix_valid));

  // R6
  mid_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && !pix_last && !ld_valid) |=> pix_valid);

endmodule

bind scan_attr_interp sai_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .span_go   (span_go),
  .span_len  (span_len),
  .span_rdy  (span_rdy),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_data  (pix_data),
  .pix_last  (pix_last)
);

// File: tb/scan_attr_interp_test.sv
module scan_attr_interp_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  localparam logic [1:0]  V_SL [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd2, 2'd1};
  localparam logic [1:0]  V_YL [NV] = '{2'd0, 2'd3, 2'd1, 2'd0, 2'd3, 2'd1};
  localparam logic [31:0] V_F  [NV] = '{32'h0001_0000, 32'h0040_1234, 32'hFFF0_0000,
                                        32'h0000_0000, 32'h1234_5678, 32'h7F00_0000};
  localparam logic [31:0] V_DE [NV] = '{32'h0000_8000, 32'hFFFF_C000, 32'h0001_2345,
                                        32'h0000_0001, 32'hFFF0_0F00, 32'h0010_0000};
  localparam logic [31:0] V_DX [NV] = '{32'h0000_4000, 32'hFFFF_F001, 32'h0003_0007,
                                        32'h8000_0000, 32'h0000_0011, 32'hFFFF_FFFF};
  localparam logic [3:0]  V_XE [NV] = '{4'd0, 4'd15, 4'd5, 4'd8, 4'd1, 4'd9};
  localparam logic [11:0] V_LN [NV] = '{12'd1, 12'd4, 12'd3, 12'd5, 12'd2, 12'd6};

  logic        clk, rst_n;
  logic [1:0]  slice_id, ld_line_lo;
  logic        ld_valid, span_go, pix_ready;
  logic [31:0] ld_f, ld_dedge, ld_dx;
  logic [3:0]  span_xerr;
  logic [11:0] span_len;
  logic        span_rdy, pix_valid, pix_last;
  logic [31:0] pix_data;

  int n_chk, n_fail;
  logic [31:0] m_edge, m_de4, m_dx;

  scan_attr_interp uut (
    .clk(clk), .rst_n(rst_n), .slice_id(slice_id), .ld_valid(ld_valid),
    .ld_line_lo(ld_line_lo), .ld_f(ld_f), .ld_dedge(ld_dedge), .ld_dx(ld_dx),
    .span_go(span_go), .span_xerr(span_xerr), .span_len(span_len),
    .span_rdy(span_rdy), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_last(pix_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] sl, input logic [1:0] yl, input logic [31:0] f,
                         input logic [31:0] de, input logic [31:0] dx, input bit with_go);
    int n, k;
    @(negedge clk);
    slice_id = sl; ld_line_lo = yl; ld_f = f; ld_dedge = de; ld_dx = dx;
    ld_valid = 1'b1; span_go = with_go; span_len = 12'd3; span_xerr = 4'd7;
    @(negedge clk);
    ld_valid = 1'b0; span_go = 1'b0;
    n = int'((sl - yl) & 2'd3);
    m_edge = f + de * 32'(n);   // R3 model
    m_de4  = de << 2;
    m_dx   = dx;
    check(!span_rdy && !pix_valid, "R10 outputs cleared after load",
          {30'd0, span_rdy, pix_valid}, 32'd0);
    k = 0;
    while (!span_rdy && k < 20) begin
      @(negedge clk);
      k++;
    end
    check(k == n + 1, "R2 pre-step latency", 32'(k), 32'(n + 1));
  endtask

  task automatic do_span(input logic [3:0] xe, input logic [11:0] len, input int stall_at,
                         input string tag);
    int k;
    longint p;
    logic [31:0] exp, held;
    @(negedge clk);
    check(span_rdy, {"R8 ready before span ", tag}, 32'(span_rdy), 32'd1);
    span_go = 1'b1; span_xerr = xe; span_len = len;
    @(negedge clk);
    span_go = 1'b0;
    if (len == 12'd0) begin
      check(span_rdy && !pix_valid, "R9 empty span keeps ready",
            {30'd0, span_rdy, pix_valid}, 32'd2);
      m_edge = m_edge + m_de4;
      return;
    end
    k = 0;
    while (!pix_valid && k < 20) begin
      @(negedge clk);
      k++;
    end
    check(k == 4, {"R5 first pixel latency ", tag}, 32'(k), 32'd4);
    p = longint'($signed(m_dx)) * longint'(xe);
    p = p >>> 4;
    exp = m_edge + p[31:0];
    for (int j = 0; j < int'(len); j++) begin
      if (j == stall_at) begin
        pix_ready = 1'b0;
        held = pix_data;
        @(negedge clk);
        check(pix_valid && pix_data == held, "R7 hold while stalled", pix_data, held);
        pix_ready = 1'b1;
      end
      check(pix_valid && pix_data == exp,
            (j == 0) ? {"R4 corrected first pixel ", tag} : {"R6 pixel step ", tag},
            pix_data, exp);
      check(pix_last == (j == int'(len) - 1), "R6 last flag",
            32'(pix_last), 32'(j == int'(len) - 1));
      @(negedge clk);
      exp = exp + m_dx;
    end
    check(span_rdy && !pix_valid, "R8 ready after last pixel", 32'(span_rdy), 32'd1);
    m_edge = m_edge + m_de4;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    slice_id = '0; ld_line_lo = '0; ld_valid = 1'b0; span_go = 1'b0; pix_ready = 1'b1;
    ld_f = '0; ld_dedge = '0; ld_dx = '0; span_xerr = '0; span_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, span_go ignored
    @(negedge clk);
    check(!span_rdy && !pix_valid, "R1 reset state", {30'd0, span_rdy, pix_valid}, 32'd0);
    span_go = 1'b1; span_len = 12'd2;
    @(negedge clk);
    span_go = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!span_rdy && !pix_valid, "R1 span_go before load ignored",
            {30'd0, span_rdy, pix_valid}, 32'd0);
    end

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      do_load(V_SL[v], V_YL[v], V_F[v], V_DE[v], V_DX[v], 1'b0);
      do_span(V_XE[v], V_LN[v], (v % 2 == 0) ? 1 : 0, "table A");
      do_span(4'd15 - V_XE[v], 12'd2, -1, "table B");
    end

    // R9: empty span still advances the edge
    do_load(2'd1, 2'd2, 32'h0002_0000, 32'h0000_1000, 32'h0000_0100, 1'b0);
    do_span(4'd3, 12'd0, -1, "empty");
    do_span(4'd3, 12'd2, -1, "R9 after empty");

    // R10: load mid-span wins
    do_load(2'd2, 2'd2, 32'h0100_0000, 32'h0000_2000, 32'h0000_0300, 1'b0);
    @(negedge clk);
    span_go = 1'b1; span_xerr = 4'd4; span_len = 12'd5;
    @(negedge clk);
    span_go = 1'b0;
    repeat (5) @(negedge clk);
    check(pix_valid, "R10 span running before reload", 32'(pix_valid), 32'd1);
    do_load(2'd0, 2'd1, 32'h0003_0000, 32'hFFFF_0000, 32'h0000_0040, 1'b0);
    do_span(4'd6, 12'd3, -1, "R10 after mid-span load");

    // R10: load and span_go in the same cycle
    do_load(2'd3, 2'd1, 32'h0000_5000, 32'h0000_0800, 32'hFFFF_FF00, 1'b1);
    do_span(4'd2, 12'd2, -1, "R10 after load with go");

    // R11: wraparound of the 32-bit sum
    do_load(2'd0, 2'd0, 32'h7FFF_F000, 32'h0000_0000, 32'h0000_0800, 1'b0);
    do_span(4'd0, 12'd5, -1, "R11 wrap");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule